// File: doc/BRIEF.md
# Split coarse/fine multi-channel PWM generator

The block drives a set of PWM outputs from a single tick counter in which one clock is one duty unit. Each channel's duty count is split in two. The coarse part is a whole number of 133-tick segments. All channels start their coarse part together at tick 0 of the frame. The fine part is the remainder. The fine parts are not run in parallel. They are played one channel after another in a fixed slot that is appended after the programmed period. A frame therefore lasts longer than the programmed period, and the duty a channel can reach is capped.

Software writes the period (in microseconds) and the per-channel duty counts through a single write port. Writes go to shadow registers. The frame plan is rebuilt from the shadow registers only on the first tick of a frame, so no frame is ever cut short or mixed. When a channel's coarse part fills the whole programmed period, the coarse part is clipped at the period end. Its fine pulse then starts right at the beginning of the slot and follows without a gap.

Top module: `pwm_split_top`

## Requirements
- R1: After reset every output is low, the period register holds INIT_PERIOD_US and every duty is 0. The first frame lasts INIT_PERIOD_US*TICKS_PER_US plus the slot ticks.
- R2: A write to address 0 sets the period in microseconds. A write to address k (1..NCH) sets the duty of channel k-1. A write to any address above NCH changes nothing.
- R3: Written values take effect only at tick 0 of the next frame. A write presented in the last tick of a frame is applied one frame later.
- R4: One duty unit is one tick. For duty d the coarse count is c = floor(d*3/400). The channel is high from tick 0 for c*133 ticks.
- R5: The fine pulse of a channel lasts d - floor(c*400/3) ticks.
- R6: A frame is P = period*TICKS_PER_US ticks followed by SLOT_US*TICKS_PER_US slot ticks. Frames repeat with no gap between them.
- R7: Fine pulses of channels whose coarse part is shorter than P are laid end to end in ascending channel order from tick P. At most one of them is high at any tick.
- R8: A channel with c*133 >= P is high for all P ticks, and its fine pulse starts at tick P with no gap.
- R9: A channel with duty 0 stays low for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock; one cycle is one duty unit |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | 0 = period, k = duty of channel k-1 |
| wr_data | input | DATA_W | Value written |
| pwm_out | output | NCH | Channel outputs |

## Verification
A wrong frame counter or plan register shows at the outputs within one frame. A rise in the middle of the programmed period, two fine pulses high together in the slot, or an edge displaced from the frame timeline all point to such a fault. A plan loaded at the wrong moment shows up as a duty change during a frame rather than at tick 0. A wrong split shows up as high-time counts per frame that differ from c*133 plus the remainder. All of these are visible by the end of the frame in which the fault occurs.

// File: rtl/pwm_split_pkg.sv
package pwm_split_pkg;

    localparam int unsigned SEG_TICKS = 133;
    localparam int unsigned SPLIT_MUL = 3;
    localparam int unsigned SPLIT_DIV = 400;
    localparam int unsigned SHORT_W   = $clog2(SEG_TICKS + 1);

    // number of whole coarse segments in a duty count
    function automatic int unsigned coarse_count(input int unsigned duty);
        return (duty * SPLIT_MUL) / SPLIT_DIV;
    endfunction

    // remainder emitted as the fine pulse
    function automatic int unsigned fine_ticks(input int unsigned duty);
        int unsigned c;
        c = coarse_count(duty);
        return duty - (c * SPLIT_DIV) / SPLIT_MUL;
    endfunction

endpackage

// File: rtl/pwm_split_regs.sv
module pwm_split_regs
    import pwm_split_pkg::*;
#(
    parameter int NCH            = 8,
    parameter int DATA_W         = 16,
    parameter int ADDR_W         = 4,
    parameter int INIT_PERIOD_US = 1000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [DATA_W-1:0]             period_q,
    output logic [NCH-1:0][DATA_W-1:0]    duty_q
);

    typedef struct packed {
        logic [DATA_W-1:0]          period;
        logic [NCH-1:0][DATA_W-1:0] duty;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (wr_en && wr_addr == '0) begin
            sh_d.period = wr_data;
        end
        for (int k = 0; k < NCH; k++) begin
            if (wr_en && int'(wr_addr) == k + 1) begin
                sh_d.duty[k] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q.period <= DATA_W'(INIT_PERIOD_US);
            sh_q.duty   <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign period_q = sh_q.period;
    assign duty_q   = sh_q.duty;

    // R2: out-of-range addresses leave every shadow register untouched
    assert_bad_addr_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) > NCH) |=> ($stable(period_q) && $stable(duty_q)));

    // R2: address 0 lands in the period register
    assert_period_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> (period_q == $past(wr_data)));

endmodule

// File: rtl/pwm_split_plan.sv
module pwm_split_plan
    import pwm_split_pkg::*;
#(
    parameter int NCH          = 8,
    parameter int DATA_W       = 16,
    parameter int CNT_W        = 23,
    parameter int TICKS_PER_US = 25,
    parameter int SLOT_US      = 100
) (
    input  logic [DATA_W-1:0]          period,
    input  logic [NCH-1:0][DATA_W-1:0] duty,
    output logic [CNT_W-1:0]           plen,
    output logic [CNT_W-1:0]           flen,
    output logic [NCH-1:0][CNT_W-1:0]  coarse_len,
    output logic [NCH-1:0][CNT_W-1:0]  fine_start,
    output logic [NCH-1:0][SHORT_W-1:0] fine_len,
    output logic [NCH-1:0]             full
);

    localparam int unsigned SLOT_TICKS = SLOT_US * TICKS_PER_US;

    always_comb begin
        int unsigned p;
        int unsigned off;
        p    = int'(period) * TICKS_PER_US;
        off  = 0;
        plen = CNT_W'(p);
        flen = CNT_W'(p + SLOT_TICKS);
        for (int k = 0; k < NCH; k++) begin
            int unsigned ct;
            int unsigned ft;
            ct            = coarse_count(int'(duty[k])) * SEG_TICKS;
            ft            = fine_ticks(int'(duty[k]));
            full[k]       = (ct >= p);
            coarse_len[k] = CNT_W'(full[k] ? p : ct);
            fine_len[k]   = SHORT_W'(ft);
            fine_start[k] = CNT_W'(full[k] ? p : p + off);
            if (!full[k]) begin
                off = off + ft;
            end
        end
    end

endmodule

// File: rtl/pwm_split_chan.sv
module pwm_split_chan
    import pwm_split_pkg::*;
#(
    parameter int CNT_W = 23
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   tick,
    input  logic [CNT_W-1:0]   plen,
    input  logic [CNT_W-1:0]   coarse_len,
    input  logic [CNT_W-1:0]   fine_start,
    input  logic [SHORT_W-1:0] fine_len,
    output logic               pwm
);

    logic in_coarse;
    logic in_fine;

    always_comb begin
        in_coarse = (tick < coarse_len);
        in_fine   = (tick >= fine_start) && (tick < fine_start + CNT_W'(fine_len));
        pwm       = in_coarse || in_fine;
    end

    // R4: inside the programmed period an output never rises after tick 0
    assert_no_rerise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick != '0 && tick < plen && !$past(pwm)) |-> !pwm);

    // R8: the coarse window never runs past the programmed period
    assert_coarse_clip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_len <= plen);

endmodule

// File: rtl/pwm_split_top.sv
module pwm_split_top
    import pwm_split_pkg::*;
#(
    parameter int NCH            = 8,
    parameter int DATA_W         = 16,
    parameter int TICKS_PER_US   = 25,
    parameter int SLOT_US        = 100,
    parameter int INIT_PERIOD_US = 1000,
    parameter int ADDR_W         = $clog2(NCH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NCH-1:0]    pwm_out
);

    localparam int CNT_W      = DATA_W + $clog2(TICKS_PER_US) + 2;
    localparam int SLOT_TICKS = SLOT_US * TICKS_PER_US;
    localparam int INIT_PLEN  = INIT_PERIOD_US * TICKS_PER_US;

    typedef struct packed {
        logic [CNT_W-1:0]            cnt;
        logic [CNT_W-1:0]            plen;
        logic [CNT_W-1:0]            flen;
        logic [NCH-1:0][CNT_W-1:0]   coarse_len;
        logic [NCH-1:0][CNT_W-1:0]   fine_start;
        logic [NCH-1:0][SHORT_W-1:0] fine_len;
        logic [NCH-1:0]              full;
    } frame_t;

    frame_t st_d, st_q;

    logic [DATA_W-1:0]           sh_period;
    logic [NCH-1:0][DATA_W-1:0]  sh_duty;
    logic [CNT_W-1:0]            nx_plen;
    logic [CNT_W-1:0]            nx_flen;
    logic [NCH-1:0][CNT_W-1:0]   nx_coarse;
    logic [NCH-1:0][CNT_W-1:0]   nx_start;
    logic [NCH-1:0][SHORT_W-1:0] nx_fine;
    logic [NCH-1:0]              nx_full;

    pwm_split_regs #(
        .NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .INIT_PERIOD_US(INIT_PERIOD_US)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .period_q(sh_period), .duty_q(sh_duty)
    );

    pwm_split_plan #(
        .NCH(NCH), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .TICKS_PER_US(TICKS_PER_US), .SLOT_US(SLOT_US)
    ) u_plan (
        .period(sh_period), .duty(sh_duty),
        .plen(nx_plen), .flen(nx_flen), .coarse_len(nx_coarse),
        .fine_start(nx_start), .fine_len(nx_fine), .full(nx_full)
    );

    // frame counter; the plan is swapped in only when the frame wraps
    always_comb begin
        st_d = st_q;
        if (st_q.cnt == st_q.flen - CNT_W'(1)) begin
            st_d.cnt        = '0;
            st_d.plen       = nx_plen;
            st_d.flen       = nx_flen;
            st_d.coarse_len = nx_coarse;
            st_d.fine_start = nx_start;
            st_d.fine_len   = nx_fine;
            st_d.full       = nx_full;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt        <= '0;
            st_q.plen       <= CNT_W'(INIT_PLEN);
            st_q.flen       <= CNT_W'(INIT_PLEN + SLOT_TICKS);
            st_q.coarse_len <= '0;
            st_q.fine_start <= '0;
            st_q.fine_len   <= '0;
            st_q.full       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pwm_split_chan #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .tick(st_q.cnt), .plen(st_q.plen),
            .coarse_len(st_q.coarse_len[g]), .fine_start(st_q.fine_start[g]),
            .fine_len(st_q.fine_len[g]), .pwm(pwm_out[g])
        );

        // R7: every fine pulse ends inside the frame
        assert_fine_fits_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.fine_start[g] + CNT_W'(st_q.fine_len[g])) <= st_q.flen);
    end

    // R6: the tick counter stays inside the frame
    assert_frame_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.flen);

    // R6: frames run tick by tick without skips
    assert_tick_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |-> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    // R3: the active plan changes only on tick 0
    assert_hold_until_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |-> ($stable(st_q.plen) && $stable(st_q.coarse_len)
                              && $stable(st_q.fine_start) && $stable(st_q.fine_len)));

    // R7: in the slot, at most one serialized fine pulse is high
    assert_slot_serial_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt >= st_q.plen) |-> $onehot0(pwm_out & ~st_q.full));

endmodule

// File: tb/tb_pwm_split_top.sv
module tb_pwm_split_top;

    localparam int NCH   = 8;
    localparam int TPU   = 25;
    localparam int SLOTU = 48;
    localparam int INITP = 8;
    localparam int SLOT  = SLOTU * TPU;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0] pwm_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // bench model of the frame timeline
    int m_cnt, m_aper, m_sper;
    int m_aduty[NCH];
    int m_sduty[NCH];

    pwm_split_top #(
        .NCH(NCH), .DATA_W(16), .TICKS_PER_US(TPU), .SLOT_US(SLOTU), .INIT_PERIOD_US(INITP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out)
    );

    always #4 clk = ~clk;

    function automatic int frame_len(int per);
        return per * TPU + SLOT;
    endfunction

    function automatic logic [7:0] exp_vec(int t, int per, int d[NCH]);
        logic [7:0] v;
        int p, off;
        p = per * TPU;
        off = 0;
        v = '0;
        for (int k = 0; k < NCH; k++) begin
            int c, ct, s, st;
            bit full;
            c  = (d[k] * 3) / 400;
            ct = c * 133;
            s  = d[k] - (c * 400) / 3;
            full = (ct >= p);
            st = full ? p : p + off;
            if (!full) off += s;
            v[k] = (t < (full ? p : ct)) || (t >= st && t < st + s);
        end
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_aper = INITP; m_sper = INITP;
            for (int k = 0; k < NCH; k++) begin m_aduty[k] = 0; m_sduty[k] = 0; end
        end else begin
            if (m_cnt == frame_len(m_aper) - 1) begin
                m_cnt = 0;
                m_aper = m_sper;
                m_aduty = m_sduty;
            end else begin
                m_cnt++;
            end
            if (wr_en) begin
                if (wr_addr == 0) m_sper = int'(wr_data);
                else if (int'(wr_addr) <= NCH) m_sduty[int'(wr_addr) - 1] = int'(wr_data);
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (tick %0d)", req, act, exp, m_cnt);
        end
    endtask

    // continuous comparison against the model
    always @(negedge clk) begin
        if (!rst_n) begin
            chk(pwm_out == 8'h00, "R1", int'(pwm_out), 0);
        end else if (!done) begin
            logic [7:0] e;
            e = exp_vec(m_cnt, m_aper, m_aduty);
            if (pwm_out !== e) begin
                string tag;
                int bad;
                bad = 0;
                for (int k = NCH - 1; k >= 0; k--) if (pwm_out[k] !== e[k]) bad = k;
                if (m_aduty[bad] == 0) tag = "R9";
                else if ((m_aduty[bad] * 3 / 400) * 133 >= m_aper * TPU) tag = "R8";
                else if (m_cnt < m_aper * TPU) tag = "R4 R3";
                else tag = "R7 R5";
                chk(1'b0, tag, int'(pwm_out), int'(e));
            end else begin
                checks++;
            end
        end
    end

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic next_frame();
        @(negedge clk);
        while (m_cnt != 0) @(negedge clk);
    endtask

    task automatic wait_tick(int t);
        while (m_cnt != t) @(negedge clk);
    endtask

    // measures high ticks per channel over one frame, starting at tick 0
    task automatic measure(output int hi[NCH], input bit probe);
        int f;
        f = frame_len(m_aper);
        for (int k = 0; k < NCH; k++) hi[k] = 0;
        for (int i = 0; i < f; i++) begin
            for (int k = 0; k < NCH; k++) hi[k] += int'(pwm_out[k]);
            if (probe) begin
                if (i == 1462) chk(pwm_out[0] == 1'b1, "R4 coarse end", int'(pwm_out[0]), 1);
                if (i == 1463) chk(pwm_out[0] == 1'b0, "R4 coarse end", int'(pwm_out[0]), 0);
                if (i == 1500) chk(pwm_out[7] == 1'b1, "R8 fine follows", int'(pwm_out[7]), 1);
                if (i == 1501) chk(pwm_out == 8'h82, "R7 slot order", int'(pwm_out), 'h82);
                if (i == 1767) chk(pwm_out == 8'h10, "R7 slot order", int'(pwm_out), 'h10);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int hi[NCH];
        int exp_hi[NCH];
        int t0, len;
        void'($urandom(32'h1c0de));
        repeat (5) @(negedge clk);
        chk(pwm_out == 8'h00, "R1 reset low", int'(pwm_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pwm_out == 8'h00, "R1 zero duty after reset", int'(pwm_out), 0);

        // directed split values, period 60 us = 1500 ticks
        wr(0, 60);
        wr(1, 1467); wr(2, 399); wr(3, 0); wr(4, 133);
        wr(5, 134); wr(6, 400); wr(7, 5); wr(8, 65535);
        next_frame();
        exp_hi = '{1464, 399, 0, 133, 134, 399, 5, 1569};
        measure(hi, 1'b1);
        for (int k = 0; k < NCH; k++)
            chk(hi[k] == exp_hi[k], (k == 2) ? "R9 zero duty" : "R4 R5 R8 high time", hi[k], exp_hi[k]);

        // R3: mid-frame write waits for the next frame
        wait_tick(100);
        wr(3, 1000);
        wait_tick(200);
        chk(pwm_out[2] == 1'b0, "R3 mid-frame write held", int'(pwm_out[2]), 0);
        next_frame();
        wait_tick(10);
        chk(pwm_out[2] == 1'b1, "R3 applied at frame start", int'(pwm_out[2]), 1);
        // R3: a write in the last tick misses that boundary
        wait_tick(frame_len(m_aper) - 1);
        wr(3, 0);
        wait_tick(10);
        chk(pwm_out[2] == 1'b1, "R3 last-tick write deferred", int'(pwm_out[2]), 1);
        next_frame();
        wait_tick(10);
        chk(pwm_out[2] == 1'b0, "R3 last-tick write applied", int'(pwm_out[2]), 0);

        // R6: rise-to-rise distance of channel 5
        while (pwm_out[5] != 1'b0) @(negedge clk);
        while (pwm_out[5] != 1'b1) @(negedge clk);
        t0 = 0;
        @(negedge clk);
        while (pwm_out[5] != 1'b0) begin t0++; @(negedge clk); end
        len = t0 + 1;
        while (pwm_out[5] != 1'b1) begin len++; @(negedge clk); end
        chk(len == 1500 + SLOT, "R6 frame length", len, 1500 + SLOT);

        // R2: addresses past the last channel are ignored
        for (int a = NCH + 1; a < 16; a++) wr(a, 16'hffff);
        next_frame();
        measure(hi, 1'b0);
        for (int k = 0; k < NCH; k++)
            chk(hi[k] == exp_hi[k], "R2 bad address ignored", hi[k], exp_hi[k]);

        // constrained random traffic checked by the model
        for (int it = 0; it < 20; it++) begin
            int per;
            per = 10 + int'($urandom % 31);
            wr(0, per);
            for (int k = 0; k < NCH; k++) begin
                int d;
                case ($urandom % 4)
                    0: d = 0;
                    1: d = int'($urandom % 400);
                    2: d = int'($urandom % (per * TPU * 3 / 2 + 1));
                    default: d = 65535 - int'($urandom % 100);
                endcase
                wr(k + 1, d);
            end
            repeat (int'($urandom % 2500) + 1) @(negedge clk);
        end
        next_frame();
        next_frame();

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", 190000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule